// File: doc/BRIEF.md
# Operand Address Generator with Direct and Indirect Fetch

This block takes a 16-bit memory-reference instruction word and works out where its data operand lives in a 64K-word data segment. It adds an 8-bit displacement to a global base. When the instruction requests indirection, it first reads a 16-bit pointer from that location and then adds the pointer to the base. It then fetches the operand itself through a single-port word memory port, either one word or a doubleword.

A caller presents the instruction, the base and a size selector together with a one-cycle start strobe. The block runs one memory read after another over a hold-until-ready handshake. It then raises a one-cycle done flag together with the operand words and the final effective address. The block serves only the global-relative addressing mode. An instruction that selects any other mode is refused with an error flag, and the block makes no memory access for it.

Top module: `opaddr_gen`

## Requirements
- R1: After reset, `done_o`, `err_o` and `mem_rd_o` are low.
- R2: With `instr_i[15]` = 0 (direct), `instr_i[8]` = 0 and displacement `instr_i[7:0]`, the block makes exactly one read for a word operand, at `base_i + disp`, and returns that word.
- R3: With `instr_i[15]` = 1 (indirect), the block first reads the pointer word at `base_i + disp`. It then reads the operand at `base_i + pointer`, so the operand can lie anywhere in the 64K-word segment.
- R4: With `dword_i` = 1, after the first operand word the block reads a second word at the effective address plus one and returns it on `opnd1_o`. With `dword_i` = 0, `opnd1_o` is 0.
- R5: All address arithmetic wraps modulo 2^16. This covers base plus displacement, base plus pointer, and the second word of a doubleword that lies at 0xFFFF.
- R6: With `instr_i[8]` = 1, the block makes no memory read. One cycle after the accepted start, it asserts `done_o` and `err_o` together.
- R7: While `mem_rd_o` is high and `mem_rdy_i` is low, `mem_rd_o` stays high and `mem_addr_o` does not change.
- R8: `done_o` lasts exactly one cycle. In that cycle `ea_o`, `opnd0_o` and `opnd1_o` are valid, and `err_o` is low for a supported mode.
- R9: A start strobe that arrives while an access is in flight, or in the done cycle, is ignored. The inputs captured at the accepted start are kept.
- R10: An instruction causes at most three reads, in this order: the pointer (if indirect), the first operand word, then the second operand word (if doubleword).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| instr_i | input | 16 | Memory-reference instruction word |
| dword_i | input | 1 | 1 = doubleword operand, 0 = word |
| base_i | input | 16 | Global base of the data segment |
| mem_addr_o | output | 16 | Memory word address |
| mem_rd_o | output | 1 | Read request, held until ready |
| mem_rdy_i | input | 1 | Memory ready, completes the current read |
| mem_data_i | input | 16 | Memory read data, valid with ready |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Unsupported mode, valid with done |
| ea_o | output | 16 | Final effective address |
| opnd0_o | output | 16 | First operand word |
| opnd1_o | output | 16 | Second operand word (0 for word access) |

## Verification
The done cycle of one instruction can coincide with a fresh start strobe, which must be refused rather than begin a new sequence. The bench drives a start on exactly the cycle in which it sees done high, on a random subset of operations. One cycle later it checks that no read request and no second done appear. A second kind of poke drives start, with a scrambled instruction and base, in the cycle right after acceptance. The bench then checks that the addresses it logs and the returned data still match the expectation computed from the original inputs.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PTR,
      ST_OPW0,
      ST_OPW1,
      ST_DONE,
      ST_ERR
   } seq_st_e;

endpackage

// File: rtl/opaddr_decode.sv
module opaddr_decode #(
   parameter int INSTR_W  = 16,
   parameter int DISP_W   = 8,
   parameter int IND_POS  = 15,
   parameter int MODE_POS = 8
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic               indirect_o,
   output logic               ext_mode_o,
   output logic [DISP_W-1:0]  disp_o
);

   if (DISP_W > MODE_POS) begin : g_bad_disp
      $error("displacement overlaps the mode bit");
   end
   if (IND_POS <= MODE_POS + 1 || IND_POS >= INSTR_W) begin : g_bad_ind
      $error("indirection bit position out of range");
   end

   assign indirect_o = instr_i[IND_POS];
   assign ext_mode_o = instr_i[MODE_POS];
   assign disp_o     = instr_i[DISP_W-1:0];

   logic unused_bits;
   assign unused_bits = ^instr_i[IND_POS-1:MODE_POS+1];

endmodule

// File: rtl/opaddr_adder.sv
module opaddr_adder #(
   parameter int AW = 16,
   parameter int OW = 8
) (
   input  logic [AW-1:0] base_i,
   input  logic [OW-1:0] off_i,
   output logic [AW-1:0] sum_o
);

   if (OW < 1 || OW > AW) begin : g_bad_ow
      $error("offset width must be between 1 and AW");
   end

   logic [AW-1:0] off_ext;

   if (OW < AW) begin : g_zext
      assign off_ext = {{(AW-OW){1'b0}}, off_i};
   end else begin : g_full
      assign off_ext = off_i;
   end

   // modulo 2^AW by truncation
   assign sum_o = base_i + off_ext;

endmodule

// File: rtl/opaddr_opbank.sv
module opaddr_opbank #(
   parameter int DW = 16,
   parameter int NW = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                clr_i,
   input  logic                                ld_i,
   input  logic [((NW > 1) ? $clog2(NW) : 1)-1:0] idx_i,
   input  logic [DW-1:0]                       data_i,
   output logic [NW-1:0][DW-1:0]               word_o
);

   localparam int IW = (NW > 1) ? $clog2(NW) : 1;

   if (NW < 1) begin : g_bad_nw
      $error("at least one operand word required");
   end

   for (genvar i = 0; i < NW; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_o[i] <= '0;
         end else if (clr_i) begin
            word_o[i] <= '0;
         end else if (ld_i && idx_i == IW'(i)) begin
            word_o[i] <= data_i;
         end
      end
   end

endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq
   import opaddr_pkg::*;
#(
   parameter int AW     = 16,
   parameter int DISP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              indirect_i,
   input  logic              ext_mode_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic              dword_i,
   input  logic [AW-1:0]     base_i,
   output logic [AW-1:0]     mem_addr_o,
   output logic              mem_rd_o,
   input  logic              mem_rdy_i,
   input  logic [AW-1:0]     mem_data_i,
   output logic              done_o,
   output logic              err_o,
   output logic [AW-1:0]     ea_o,
   output logic              clr_o,
   output logic              ld_o,
   output logic              ld_idx_o
);

   seq_st_e       state_q;
   logic [AW-1:0] base_r;
   logic [AW-1:0] addr_r;
   logic          dword_r;
   logic [AW-1:0] dir_sum;
   logic [AW-1:0] ptr_sum;

   opaddr_adder #(.AW(AW), .OW(DISP_W)) u_dir_add (
      .base_i (base_i),
      .off_i  (disp_i),
      .sum_o  (dir_sum)
   );

   opaddr_adder #(.AW(AW), .OW(AW)) u_ptr_add (
      .base_i (base_r),
      .off_i  (mem_data_i),
      .sum_o  (ptr_sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_r  <= '0;
         addr_r  <= '0;
         dword_r <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               base_r  <= base_i;
               dword_r <= dword_i;
               addr_r  <= dir_sum;
               if (ext_mode_i)      state_q <= ST_ERR;
               else if (indirect_i) state_q <= ST_PTR;
               else                 state_q <= ST_OPW0;
            end
            ST_PTR: if (mem_rdy_i) begin
               addr_r  <= ptr_sum;
               state_q <= ST_OPW0;
            end
            ST_OPW0: if (mem_rdy_i) begin
               state_q <= dword_r ? ST_OPW1 : ST_DONE;
            end
            ST_OPW1: if (mem_rdy_i) begin
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd_o   = (state_q == ST_PTR) || (state_q == ST_OPW0) || (state_q == ST_OPW1);
   assign mem_addr_o = (state_q == ST_OPW1) ? addr_r + AW'(1) : addr_r;
   assign done_o     = (state_q == ST_DONE) || (state_q == ST_ERR);
   assign err_o      = (state_q == ST_ERR);
   assign ea_o       = addr_r;
   assign clr_o      = (state_q == ST_IDLE) && start_i;
   assign ld_o       = mem_rdy_i && ((state_q == ST_OPW0) || (state_q == ST_OPW1));
   assign ld_idx_o   = (state_q == ST_OPW1);

   // R7: request and address held while memory stalls
   p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o && !mem_rdy_i |=> mem_rd_o && $stable(mem_addr_o));

   // R3: operand address follows the fetched pointer
   p_ptr_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PTR) && mem_rdy_i |=>
         mem_rd_o && (mem_addr_o == AW'(base_r + $past(mem_data_i))));

   // R4: second word read at the next (wrapping) address
   p_second_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OPW0) && mem_rdy_i && dword_r |=>
         mem_rd_o && (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

   // R6: unsupported mode finishes at once without a read
   p_bad_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) && start_i && ext_mode_i |=> done_o && err_o && !mem_rd_o);

   // R8: done is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9: a start during a read does not abort the read
   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o && start_i && !mem_rdy_i |=> mem_rd_o);

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
   parameter int AW       = 16,
   parameter int DISP_W   = 8,
   parameter int IND_POS  = 15,
   parameter int MODE_POS = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [15:0]   instr_i,
   input  logic          dword_i,
   input  logic [AW-1:0] base_i,
   output logic [AW-1:0] mem_addr_o,
   output logic          mem_rd_o,
   input  logic          mem_rdy_i,
   input  logic [AW-1:0] mem_data_i,
   output logic          done_o,
   output logic          err_o,
   output logic [AW-1:0] ea_o,
   output logic [AW-1:0] opnd0_o,
   output logic [AW-1:0] opnd1_o
);

   localparam int NWORDS = 2;

   logic              indirect;
   logic              ext_mode;
   logic [DISP_W-1:0] disp;
   logic              clr;
   logic              ld;
   logic              ld_idx;
   logic [NWORDS-1:0][AW-1:0] words;

   opaddr_decode #(
      .INSTR_W (16),
      .DISP_W  (DISP_W),
      .IND_POS (IND_POS),
      .MODE_POS(MODE_POS)
   ) u_dec (
      .instr_i    (instr_i),
      .indirect_o (indirect),
      .ext_mode_o (ext_mode),
      .disp_o     (disp)
   );

   opaddr_seq #(.AW(AW), .DISP_W(DISP_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .indirect_i (indirect),
      .ext_mode_i (ext_mode),
      .disp_i     (disp),
      .dword_i    (dword_i),
      .base_i     (base_i),
      .mem_addr_o (mem_addr_o),
      .mem_rd_o   (mem_rd_o),
      .mem_rdy_i  (mem_rdy_i),
      .mem_data_i (mem_data_i),
      .done_o     (done_o),
      .err_o      (err_o),
      .ea_o       (ea_o),
      .clr_o      (clr),
      .ld_o       (ld),
      .ld_idx_o   (ld_idx)
   );

   opaddr_opbank #(.DW(AW), .NW(NWORDS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .ld_i   (ld),
      .idx_i  (ld_idx),
      .data_i (mem_data_i),
      .word_o (words)
   );

   assign opnd0_o = words[0];
   assign opnd1_o = words[1];

endmodule

// File: tb/opaddr_gen_tb.sv
`timescale 1ns/1ps
module opaddr_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] instr_i = '0;
   logic        dword_i = 1'b0;
   logic [15:0] base_i = '0;
   logic [15:0] mem_addr_o;
   logic        mem_rd_o;
   logic        mem_rdy_i = 1'b0;
   logic [15:0] mem_data_i = '0;
   logic        done_o, err_o;
   logic [15:0] ea_o, opnd0_o, opnd1_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] log_q[$];
   logic        ovr_en = 1'b0;
   logic [15:0] ovr_a = '0, ovr_v = '0;
   logic        hold_pend = 1'b0;
   logic [15:0] hold_addr = '0;

   always #2.5 clk = ~clk;

   opaddr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
      .dword_i(dword_i), .base_i(base_i), .mem_addr_o(mem_addr_o),
      .mem_rd_o(mem_rd_o), .mem_rdy_i(mem_rdy_i), .mem_data_i(mem_data_i),
      .done_o(done_o), .err_o(err_o), .ea_o(ea_o),
      .opnd0_o(opnd0_o), .opnd1_o(opnd1_o)
   );

   function automatic logic [15:0] mem_val(input logic [15:0] a);
      logic [31:0] t;
      if (ovr_en && a == ovr_a) return ovr_v;
      t = a * 32'h9E37;
      return t[15:0] ^ 16'h3C5A;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   // memory model: random ready latency, logs each completed read address
   always @(negedge clk) begin
      if (hold_pend) begin
         chk(mem_rd_o && mem_addr_o == hold_addr, "R7", mem_addr_o, hold_addr);
         hold_pend = 1'b0;
      end
      if (rst_n && mem_rd_o) begin
         mem_data_i = mem_val(mem_addr_o);
         if ($urandom_range(0, 2) != 0) begin
            mem_rdy_i = 1'b1;
            log_q.push_back(mem_addr_o);
         end else begin
            mem_rdy_i = 1'b0;
            hold_pend = 1'b1;
            hold_addr = mem_addr_o;
         end
      end else begin
         mem_rdy_i  = 1'b0;
         mem_data_i = 16'($urandom);
      end
   end

   // poke: 0 none, 1 start right after acceptance, 2 start on the done cycle
   task automatic do_op(input logic [15:0] ins, input logic [15:0] bs,
                        input bit dw, input int poke, input string tg);
      logic [15:0] exp_q[$];
      logic [15:0] a, ea, ptr;
      int cyc;
      bit bad_mode;
      bad_mode = ins[8];
      a = bs + {8'h00, ins[7:0]};
      ea = a;
      if (!bad_mode) begin
         if (ins[15]) begin
            exp_q.push_back(a);
            ptr = mem_val(a);
            ea = bs + ptr;
         end
         exp_q.push_back(ea);
         if (dw) exp_q.push_back(ea + 16'd1);
      end
      log_q.delete();
      @(negedge clk);
      instr_i = ins; base_i = bs; dword_i = dw; start_i = 1'b1;
      @(negedge clk);
      if (poke == 1) begin
         instr_i = 16'($urandom) | 16'h0100;
         base_i  = 16'($urandom);
         dword_i = ~dw;
         start_i = 1'b1;
      end else begin
         start_i = 1'b0;
      end
      cyc = 0;
      while (!done_o && cyc < 1000) begin
         @(negedge clk);
         start_i = 1'b0;
         cyc++;
      end
      chk(done_o, "R8", done_o, 1);
      if (bad_mode) begin
         chk(err_o, "R6", err_o, 1);
         chk(log_q.size() == 0, "R6", log_q.size(), 0);
      end else begin
         chk(!err_o, "R8", err_o, 0);
         chk(ea_o == ea, tg, ea_o, ea);
         chk(opnd0_o == mem_val(ea), dw ? "R4" : tg, opnd0_o, mem_val(ea));
         chk(opnd1_o == (dw ? mem_val(ea + 16'd1) : 16'h0000), "R4",
             opnd1_o, dw ? mem_val(ea + 16'd1) : 16'h0000);
         chk(log_q.size() == exp_q.size(), "R10", log_q.size(), exp_q.size());
         if (log_q.size() == exp_q.size()) begin
            for (int i = 0; i < exp_q.size(); i++)
               chk(log_q[i] == exp_q[i], ins[15] ? "R3" : "R2", log_q[i], exp_q[i]);
         end
      end
      if (poke == 2) begin
         instr_i = 16'($urandom) & 16'hFEFF;
         start_i = 1'b1;
      end else begin
         start_i = 1'b0;
      end
      @(negedge clk);
      start_i = 1'b0;
      chk(!done_o, "R8", done_o, 0);
      chk(!mem_rd_o, "R9", mem_rd_o, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog act=hung exp=done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(!done_o, "R1", done_o, 0);
      chk(!err_o, "R1", err_o, 0);
      chk(!mem_rd_o, "R1", mem_rd_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_o && !mem_rd_o, "R1", {done_o, mem_rd_o}, 0);

      // directed: pointer at displacement 11 holds 1037
      ovr_en = 1'b1; ovr_a = 16'd11; ovr_v = 16'd1037;
      do_op(16'h800B, 16'h0000, 1'b0, 0, "R3");
      do_op(16'h000B, 16'h0000, 1'b0, 0, "R2");
      // wrap of base plus displacement
      ovr_en = 1'b0;
      do_op(16'h0020, 16'hFFF0, 1'b1, 0, "R5");
      // doubleword at the top of the segment, reached via pointer
      ovr_en = 1'b1; ovr_a = 16'h0005; ovr_v = 16'hFFFF;
      do_op(16'h8005, 16'h0000, 1'b1, 0, "R5");
      // wrap of base plus pointer
      ovr_a = 16'h8010; ovr_v = 16'h9000;
      do_op(16'h8010, 16'h8000, 1'b0, 0, "R5");
      ovr_en = 1'b0;
      // unsupported mode, with pokes
      do_op(16'h0107, 16'h1234, 1'b0, 0, "R6");
      do_op(16'h81FF, 16'h0000, 1'b1, 2, "R6");
      // busy pokes on good instructions
      do_op(16'h8033, 16'h4000, 1'b1, 1, "R9");
      do_op(16'h0044, 16'h2000, 1'b0, 2, "R9");

      for (int k = 0; k < 400; k++) begin
         logic [15:0] ins;
         ins = 16'($urandom);
         if ($urandom_range(0, 7) != 0) ins[8] = 1'b0;
         do_op(ins, 16'($urandom), 1'($urandom), $urandom_range(0, 2),
               ins[15] ? "R3" : "R2");
      end

      summary();
      $finish;
   end

endmodule